// File: doc/BRIEF.md
# Display Init Command Sequencer

After reset, this block plays back a fixed power-up program for a TFT display controller, one byte at a time. Each byte goes to a downstream serial-link driver through a valid/ready handshake. A side flag marks each byte as a command or as a parameter (data). The program lives in a small read-only table inside the block. Each table entry is tagged as command byte, data byte, timed wait or end.

The controller's extended registers have 16-bit addresses, and the program reaches them in two steps. It first sends command 00h with the low address byte as its parameter. It then sends the high address byte as a command, followed by one or more parameter bytes, which land on consecutive low addresses.

The program runs in this order:
- It unlocks the extended command set.
- It selects display inversion, which a normally-white panel needs.
- It loads a burst of sixteen gamma values.
- It waits, sends sleep-out, waits longer, and sends display-on.

The block waits for a start pulse before it sends anything. After the last byte is taken, it holds a done flag high.

Top module: `disp_init_seq`

## Requirements
- R1: While reset is high and after reset until the first start pulse, o_valid and o_done are 0. A reset in the middle of the program clears both, and the next start replays the program from its first byte.
- R2: The first eleven bytes unlock the extended command set. Each is written as flag:byte, where flag 0 means command and flag 1 means data. The bytes are 0:00, 1:00, 0:FF, 1:80, 1:09, 1:01, 0:00, 1:80, 0:FF, 1:80, 1:09.
- R3: The inversion select follows as an offset pair and a command. The bytes are 0:00, 1:00, 0:21.
- R4: The gamma burst follows. It is 0:00, 1:00, 0:E1, then sixteen data bytes: 20 21 22 0B 04 17 0C 0D 00 04 03 06 0D 24 21 1A.
- R5: A wait of 50 ms precedes the sleep-out command 0:11. Between the handshake of the previous byte and o_valid rising for 11h there are at least 50*CYC_PER_MS cycles and at most 8 more. o_valid stays low throughout.
- R6: A wait of 150 ms separates the acceptance of 11h from the display-on command 0:29. It has the same bounds as R5, using 150*CYC_PER_MS.
- R7: While o_valid is high and i_ready is low, o_valid, o_byte and o_is_data hold their values.
- R8: Each handshake (o_valid and i_ready both high at a rising edge) consumes exactly one byte. The 35 bytes arrive in order, with none skipped or repeated.
- R9: o_done rises only after the last byte has been accepted. It then stays high, o_valid stays low, and further start pulses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| i_start | input | 1 | One-cycle pulse that begins playback |
| i_ready | input | 1 | Downstream can take a byte |
| o_valid | output | 1 | o_byte and o_is_data hold a byte on offer |
| o_byte | output | 8 | Byte on offer |
| o_is_data | output | 1 | 0 = command byte, 1 = parameter byte |
| o_done | output | 1 | Whole program sent, sticky until reset |

## Verification
The hardest case to reach is a stall that lands exactly on a fetch from the table, while the next entry is already waiting to be sent. That is where a byte would be skipped or sent twice. The bench drops ready for three cycles on every fourth byte, so stalls fall at many different points in the program. The timed waits are reached by shrinking CYC_PER_MS to four cycles. The bench then measures the gap from the last handshake to the next valid, in clock edges.

// File: rtl/dis_pkg.sv
package dis_pkg;

  localparam int BYTE_W    = 8;
  localparam int VAL_W     = 16;
  localparam int ROM_DEPTH = 38;
  localparam int ROM_AW    = $clog2(ROM_DEPTH);

  typedef enum logic [1:0] {
    K_CMD  = 2'd0,
    K_DAT  = 2'd1,
    K_WAIT = 2'd2,
    K_END  = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e            kind;
    logic [VAL_W-1:0] val;
  } entry_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_EXEC,
    S_WAIT,
    S_DONE
  } seq_state_e;

  function automatic entry_t mk(kind_e k, int v);
    entry_t e;
    e.kind = k;
    e.val  = VAL_W'(v);
    return e;
  endfunction

  // gamma curve values, positive polarity
  function automatic logic [BYTE_W-1:0] gamma_val(int i);
    case (i)
      0:  return 8'h20;
      1:  return 8'h21;
      2:  return 8'h22;
      3:  return 8'h0B;
      4:  return 8'h04;
      5:  return 8'h17;
      6:  return 8'h0C;
      7:  return 8'h0D;
      8:  return 8'h00;
      9:  return 8'h04;
      10: return 8'h03;
      11: return 8'h06;
      12: return 8'h0D;
      13: return 8'h24;
      14: return 8'h21;
      default: return 8'h1A;
    endcase
  endfunction

  function automatic entry_t prog_entry(int idx);
    if (idx >= 17 && idx <= 32) return mk(K_DAT, int'(gamma_val(idx - 17)));
    case (idx)
      // unlock: FF00h <= 80 09 01
      0:  return mk(K_CMD, 8'h00);
      1:  return mk(K_DAT, 8'h00);
      2:  return mk(K_CMD, 8'hFF);
      3:  return mk(K_DAT, 8'h80);
      4:  return mk(K_DAT, 8'h09);
      5:  return mk(K_DAT, 8'h01);
      // unlock: FF80h <= 80 09
      6:  return mk(K_CMD, 8'h00);
      7:  return mk(K_DAT, 8'h80);
      8:  return mk(K_CMD, 8'hFF);
      9:  return mk(K_DAT, 8'h80);
      10: return mk(K_DAT, 8'h09);
      // inversion for normally-white cell
      11: return mk(K_CMD, 8'h00);
      12: return mk(K_DAT, 8'h00);
      13: return mk(K_CMD, 8'h21);
      // gamma burst base E100h
      14: return mk(K_CMD, 8'h00);
      15: return mk(K_DAT, 8'h00);
      16: return mk(K_CMD, 8'hE1);
      // power-up tail
      33: return mk(K_WAIT, 50);
      34: return mk(K_CMD, 8'h11);
      35: return mk(K_WAIT, 150);
      36: return mk(K_CMD, 8'h29);
      default: return mk(K_END, 0);
    endcase
  endfunction

endpackage

// File: rtl/dis_rom.sv
module dis_rom
  import dis_pkg::*;
#(
  parameter int DEPTH = ROM_DEPTH,
  parameter int AW    = ROM_AW
) (
  input  logic          clk,
  input  logic [AW-1:0] i_addr,
  output entry_t        o_q
);

  // synchronous read so the table maps onto a block RAM
  always_ff @(posedge clk) begin
    if (int'(i_addr) < DEPTH) o_q <= prog_entry(int'(i_addr));
    else                      o_q <= mk(K_END, 0);
  end

endmodule

// File: rtl/dis_wait_timer.sv
module dis_wait_timer #(
  parameter int MS_W       = 16,
  parameter int CYC_PER_MS = 100000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            i_start,
  input  logic [MS_W-1:0] i_ms,
  output logic            o_busy
);

  localparam int CW = $clog2(CYC_PER_MS + 1);

  logic [MS_W-1:0] ms_left;
  logic [CW-1:0]   cyc_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      ms_left  <= '0;
      cyc_left <= '0;
      o_busy   <= 1'b0;
    end else if (i_start) begin
      ms_left  <= i_ms;
      cyc_left <= CW'(CYC_PER_MS - 1);
      o_busy   <= (i_ms != '0);
    end else if (o_busy) begin
      if (cyc_left == '0) begin
        if (ms_left == MS_W'(1)) begin
          o_busy <= 1'b0;
        end else begin
          ms_left  <= ms_left - MS_W'(1);
          cyc_left <= CW'(CYC_PER_MS - 1);
        end
      end else begin
        cyc_left <= cyc_left - CW'(1);
      end
    end
  end

  AST_TMR_START_IDLE: assert property (@(posedge clk) disable iff (rst)
    i_start |-> !o_busy); // R5

endmodule

// File: rtl/dis_byte_out.sv
module dis_byte_out #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         i_load,
  input  logic [W-1:0] i_byte,
  input  logic         i_is_data,
  input  logic         i_ready,
  output logic         o_valid,
  output logic [W-1:0] o_byte,
  output logic         o_is_data,
  output logic         o_free
);

  assign o_free = !o_valid || i_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid   <= 1'b0;
      o_byte    <= '0;
      o_is_data <= 1'b0;
    end else if (i_load) begin
      o_valid   <= 1'b1;
      o_byte    <= i_byte;
      o_is_data <= i_is_data;
    end else if (i_ready) begin
      o_valid   <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !i_ready) |=> (o_valid && $stable(o_byte) && $stable(o_is_data))); // R7

  AST_LOAD_ONLY_FREE: assert property (@(posedge clk) disable iff (rst)
    i_load |-> (!o_valid || i_ready)); // R8

endmodule

// File: rtl/disp_init_seq.sv
module disp_init_seq
  import dis_pkg::*;
#(
  parameter int CLK_MHZ    = 100,
  parameter int CYC_PER_MS = CLK_MHZ * 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              i_start,
  input  logic              i_ready,
  output logic              o_valid,
  output logic [BYTE_W-1:0] o_byte,
  output logic              o_is_data,
  output logic              o_done
);

  localparam int AW = ROM_AW;

  seq_state_e  st;
  logic [AW-1:0] ptr;
  entry_t      rom_q;
  logic        slot_free;
  logic        tmr_busy;
  logic        emit;
  logic        tmr_go;
  logic        is_byte;

  dis_rom #(.DEPTH(ROM_DEPTH), .AW(AW)) i_rom (
    .clk    (clk),
    .i_addr (ptr),
    .o_q    (rom_q)
  );

  dis_wait_timer #(.MS_W(VAL_W), .CYC_PER_MS(CYC_PER_MS)) i_tmr (
    .clk     (clk),
    .rst     (rst),
    .i_start (tmr_go),
    .i_ms    (rom_q.val),
    .o_busy  (tmr_busy)
  );

  dis_byte_out #(.W(BYTE_W)) i_out (
    .clk       (clk),
    .rst       (rst),
    .i_load    (emit),
    .i_byte    (rom_q.val[BYTE_W-1:0]),
    .i_is_data (rom_q.kind == K_DAT),
    .i_ready   (i_ready),
    .o_valid   (o_valid),
    .o_byte    (o_byte),
    .o_is_data (o_is_data),
    .o_free    (slot_free)
  );

  assign is_byte = (rom_q.kind == K_CMD) || (rom_q.kind == K_DAT);
  assign emit    = (st == S_EXEC) && is_byte && slot_free;
  // waits start only once every earlier byte has been taken
  assign tmr_go  = (st == S_EXEC) && (rom_q.kind == K_WAIT) && !o_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      ptr    <= '0;
      o_done <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (i_start) st <= S_LOAD;
        S_LOAD: st <= S_EXEC;
        S_EXEC: begin
          if (emit || tmr_go) begin
            ptr <= ptr + AW'(1);
            st  <= emit ? S_LOAD : S_WAIT;
          end else if (rom_q.kind == K_END && !o_valid) begin
            st     <= S_DONE;
            o_done <= 1'b1;
          end
        end
        S_WAIT: if (!tmr_busy) st <= S_LOAD;
        default: st <= S_DONE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) |-> (!o_valid && !o_done)); // R1

  AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (rst)
    tmr_busy |-> !o_valid); // R5

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (ptr != $past(ptr)) |-> (ptr == $past(ptr) + AW'(1))); // R8

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    o_done |=> o_done); // R9

  AST_DONE_NO_BYTE: assert property (@(posedge clk) disable iff (rst)
    o_done |-> !o_valid); // R9

endmodule

// File: tb/test_disp_init_seq.sv
module test_disp_init_seq;

  localparam int NB   = 35;
  localparam int CPM  = 4;
  localparam int WD   = 100000;

  localparam logic [8:0] EXP [NB] = '{
    9'h000, 9'h100, 9'h0FF, 9'h180, 9'h109, 9'h101,
    9'h000, 9'h180, 9'h0FF, 9'h180, 9'h109,
    9'h000, 9'h100, 9'h021,
    9'h000, 9'h100, 9'h0E1,
    9'h120, 9'h121, 9'h122, 9'h10B, 9'h104, 9'h117, 9'h10C, 9'h10D,
    9'h100, 9'h104, 9'h103, 9'h106, 9'h10D, 9'h124, 9'h121, 9'h11A,
    9'h011, 9'h029
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       i_start = 1'b0;
  logic       i_ready = 1'b0;
  logic       o_valid;
  logic [7:0] o_byte;
  logic       o_is_data;
  logic       o_done;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int last_acc = 0;
  int last_seen = 0;
  bit finished = 0;

  disp_init_seq #(.CLK_MHZ(200), .CYC_PER_MS(CPM)) i_disp_init_seq (
    .clk       (clk),
    .rst       (rst),
    .i_start   (i_start),
    .i_ready   (i_ready),
    .o_valid   (o_valid),
    .o_byte    (o_byte),
    .o_is_data (o_is_data),
    .o_done    (o_done)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(int i);
    if (i < 11) return "R2";
    if (i < 14) return "R3";
    if (i < 33) return "R4";
    if (i == 33) return "R5";
    return "R6";
  endfunction

  task automatic pulse_start();
    @(negedge clk) i_start = 1'b1;
    @(negedge clk) i_start = 1'b0;
  endtask

  // take byte i: wait for valid, compare, optionally stall, then hand over
  task automatic take(int i);
    logic [8:0] got;
    while (!o_valid) @(negedge clk);
    last_seen = cyc;
    got = {o_is_data, o_byte};
    chk(req_of(i), $sformatf("byte %0d (R8 order)", i), int'(got), int'(EXP[i]));
    if (i % 4 == 2) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk("R7", $sformatf("hold during stall, byte %0d", i),
            int'({o_valid, o_is_data, o_byte}), int'({1'b1, got}));
      end
    end
    i_ready = 1'b1;
    @(negedge clk);
    i_ready = 1'b0;
    last_acc = cyc;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > WD && !finished) begin
        failures++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    bit seen_valid;
    int gap;

    repeat (5) @(negedge clk);
    chk("R1", "valid in reset", int'(o_valid), 0);
    chk("R1", "done in reset", int'(o_done), 0);
    rst = 1'b0;

    seen_valid = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (o_valid || o_done) seen_valid = 1;
    end
    chk("R1", "output before start", int'(seen_valid), 0);

    // partial run, then reset in the middle
    pulse_start();
    for (int i = 0; i < 5; i++) take(i);
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "valid after mid-run reset", int'(o_valid), 0);
    chk("R1", "done after mid-run reset", int'(o_done), 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    chk("R1", "quiet before restart", int'(o_valid), 0);

    // full program walk
    pulse_start();
    for (int i = 0; i < NB; i++) begin
      int prev_acc;
      prev_acc = last_acc;
      if (i == NB - 1) chk("R9", "done before last byte", int'(o_done), 0);
      take(i);
      gap = last_seen - prev_acc;
      if (i == 33) begin
        chk("R5", "gap before 11h not short", int'(gap >= 50 * CPM), 1);
        chk("R5", "gap before 11h not long", int'(gap <= 50 * CPM + 8), 1);
      end
      if (i == 34) begin
        chk("R6", "gap before 29h not short", int'(gap >= 150 * CPM), 1);
        chk("R6", "gap before 29h not long", int'(gap <= 150 * CPM + 8), 1);
      end
    end

    repeat (8) @(negedge clk);
    chk("R9", "done after last byte", int'(o_done), 1);
    pulse_start();
    seen_valid = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (o_valid || !o_done) seen_valid = 1;
    end
    chk("R9", "done sticky, no bytes after restart pulse", int'(seen_valid), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule